// File: doc/BRIEF.md
# Multi-Format Serial Audio Output Formatter

This block takes decoded stereo sample pairs as parallel words and sends them out on one serial data line. It generates its own bit clock and frame clock. A 2-bit format select picks one of four framings: 16-bit right-justified, 24-bit right-justified, 24-bit left-justified, or 24-bit I2S. Every sample goes out MSB first in two's complement. Only the position of the bits inside each half-frame and the polarity of the frame clock depend on the format.

Each frame lasts 64 bit-clock periods: 32 for the left channel, then 32 for the right. A pair accepted at any point in a frame is transmitted exactly three frames later. A block-frame indicator comes out with the same latency. It is high for the whole frame that carries a pair which was tagged with the block-start flag. The format select is sampled only at frame boundaries.

Top module: `audio_serial_fmt`

## Requirements
- R1: Format code 2'b00 selects 16-bit right-justified, 2'b01 selects 24-bit right-justified, 2'b10 selects 24-bit left-justified and 2'b11 selects 24-bit I2S. Every sample is sent MSB first in its two's-complement form.
- R2: The bit clock has a period of BCK_DIV system clocks. It is low for the first half of each period and low straight after reset. A frame lasts 64 bit-clock periods, and channel slot s (0..31) holds bit periods s and 32+s.
- R3: The frame clock is high during the left half in codes 00, 01 and 10, and low during the left half in code 11. The frame clock and the data change only on a falling edge of the bit clock.
- R4: In code 10, slot s < 24 carries sample bit 23-s and slots 24..31 carry 0.
- R5: In code 11, slot 0 carries 0, slot s in 1..24 carries sample bit 24-s, and slots 25..31 carry 0.
- R6: In code 01, slots 0..7 carry 0 and slot s in 8..31 carries sample bit 31-s.
- R7: In code 00, slots 0..15 carry 0 and slot s in 16..31 carries sample bit 39-s. Only sample bits 23..8 are sent, with no rounding.
- R8: A pair accepted while frame k is running, including in its last system clock, is transmitted in frame k+3. If several pairs are accepted in one frame, the last one is sent.
- R9: The block-frame output is high for the whole of frame k+3 exactly when the pair sent in that frame was accepted with the block-start flag high. It changes only at frame starts.
- R10: The format select is sampled in the last system clock of each frame and applies to the whole next frame. Changes that are undone before a frame's last clock have no effect.
- R11: Reset clears the pipeline. The data and block-frame outputs are low and the frame clock is high. A frame that holds no accepted pair sends all zeros with the block-frame output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| fmt_i | input | 2 | Output format select |
| left_i | input | SAMPLE_W | Left sample word |
| right_i | input | SAMPLE_W | Right sample word |
| valid_i | input | 1 | Accept strobe for the sample pair |
| block_start_i | input | 1 | Marks the pair as the first of a channel-status block |
| bck_o | output | 1 | Bit clock |
| lrck_o | output | 1 | Frame (word) clock |
| sdata_o | output | 1 | Serial audio data |
| bframe_o | output | 1 | Block-frame indicator |

## Verification
A pair that is accepted while frame k is running shows up in frame k+3, and the block-frame bit shows up in that same frame. A format code sampled in a frame's last clock shapes the next frame. The bit clock and frame clock are pure functions of the system-clock count since reset. The bench keeps that count, stores each accepted pair and each sampled format code under the number of the frame it belongs to, and derives every expected output from those records for the current cycle. It compares all four outputs on every falling system-clock edge, half a clock after the registers update, so each result is checked in the exact cycle it is due. The stimulus places pairs on a frame's last clock, sends two pairs within one frame, leaves some frames empty, and changes the format code both mid-frame and in a frame's last clock.

// File: rtl/audio_serial_fmt.sv
module audio_serial_fmt #(
  parameter int SAMPLE_W = 24,
  parameter int BCK_DIV  = 4
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic [1:0]          fmt_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  input  logic                valid_i,
  input  logic                block_start_i,
  output logic                bck_o,
  output logic                lrck_o,
  output logic                sdata_o,
  output logic                bframe_o
);
  localparam int PH_W   = (BCK_DIV > 2) ? $clog2(BCK_DIV) : 1;
  localparam int SLOT   = 32;
  localparam int SHORT  = 16;
  localparam int POS_W  = $clog2(SAMPLE_W);

  typedef struct packed {
    logic                vld;
    logic                blk;
    logic [SAMPLE_W-1:0] l;
    logic [SAMPLE_W-1:0] r;
  } pair_t;

  logic [PH_W-1:0] phase_q;
  logic [5:0]      bit_q;
  logic [1:0]      fmt_q;
  pair_t           cap_q, st1_q, st2_q, tx_q, cap_in;

  wire last_ph   = phase_q == PH_W'(BCK_DIV - 1);
  wire frame_end = last_ph && (bit_q == 6'd63);

  always_comb begin
    cap_in = cap_q;
    if (valid_i) cap_in = '{vld: 1'b1, blk: block_start_i, l: left_i, r: right_i};
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      phase_q <= '0;
      bit_q   <= '0;
      fmt_q   <= '0;
      cap_q   <= '0;
      st1_q   <= '0;
      st2_q   <= '0;
      tx_q    <= '0;
    end else begin
      phase_q <= last_ph ? '0 : phase_q + 1'b1;
      if (last_ph) bit_q <= bit_q + 6'd1;
      if (frame_end) begin
        fmt_q <= fmt_i;
        st1_q <= cap_in;
        st2_q <= st1_q;
        tx_q  <= st2_q;
        cap_q <= '0;
      end else begin
        cap_q <= cap_in;
      end
    end
  end

  wire                left_half = !bit_q[5];
  wire [4:0]          slot      = bit_q[4:0];
  wire [SAMPLE_W-1:0] word      = left_half ? tx_q.l : tx_q.r;

  logic             hit;
  logic [POS_W-1:0] pos;

  always_comb begin
    hit = 1'b0;
    pos = '0;
    unique case (fmt_q)
      2'b00: begin
        hit = int'(slot) >= SLOT - SHORT;
        pos = POS_W'(SLOT - 1 - int'(slot) + SAMPLE_W - SHORT);
      end
      2'b01: begin
        hit = int'(slot) >= SLOT - SAMPLE_W;
        pos = POS_W'(SLOT - 1 - int'(slot));
      end
      2'b10: begin
        hit = int'(slot) < SAMPLE_W;
        pos = POS_W'(SAMPLE_W - 1 - int'(slot));
      end
      default: begin
        hit = (slot != 5'd0) && (int'(slot) <= SAMPLE_W);
        pos = POS_W'(SAMPLE_W - int'(slot));
      end
    endcase
  end

  assign bck_o    = phase_q >= PH_W'(BCK_DIV / 2);
  assign lrck_o   = (fmt_q == 2'b11) ? !left_half : left_half;
  assign sdata_o  = tx_q.vld && hit && word[pos];
  assign bframe_o = tx_q.vld && tx_q.blk;

  p_fall_only_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$stable(sdata_o) || !$stable(lrck_o)) |-> $fell(bck_o));

  p_lrck_half_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(lrck_o) |-> (phase_q == '0 && slot == 5'd0));

  p_bframe_frame_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(bframe_o) |-> (phase_q == '0 && bit_q == 6'd0));

  p_fmt_boundary_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(fmt_q) |-> (phase_q == '0 && bit_q == 6'd0));

endmodule

// File: tb/test_audio_serial_fmt.sv
module test_audio_serial_fmt;
  localparam int CLK_PER = 10;
  localparam int DIV     = 4;
  localparam int FR      = 64 * DIV;
  localparam int NFR     = 28;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  fmt = 2'b00;
  logic [23:0] lin = '0, rin = '0;
  logic        vin = 1'b0, bin = 1'b0;
  logic        bck, lrck, sdata, bframe;

  int checks = 0;
  int errors = 0;
  int t = 0;
  logic [49:0] acc [int];
  logic [1:0]  fmtf [int];

  audio_serial_fmt #(.SAMPLE_W(24), .BCK_DIV(DIV)) i_audio_serial_fmt (
    .clk_i(clk), .rst_i(rst), .fmt_i(fmt), .left_i(lin), .right_i(rin),
    .valid_i(vin), .block_start_i(bin),
    .bck_o(bck), .lrck_o(lrck), .sdata_o(sdata), .bframe_o(bframe));

  always #(CLK_PER / 2) clk = ~clk;

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s t=%0d actual=%b expected=%b", tag, t, act, exp);
    end
  endtask

  // Model update: accepted pairs keyed by frame (R8), format sampled in last clock (R10)
  always @(posedge clk) begin
    if (rst) begin
      t = 0;
      acc.delete();
    end else begin
      if (vin) acc[t / FR] = {1'b1, bin, lin, rin};
      if (t % FR == FR - 1) fmtf[t / FR + 1] = fmt;
      t = t + 1;
    end
  end

  always @(negedge clk) begin
    int f, b, s;
    logic [1:0] ef;
    logic [49:0] pr;
    logic [23:0] w;
    logic left, e_lr, e_d;
    f  = t / FR;
    b  = (t % FR) / DIV;
    s  = b % 32;
    ef = fmtf.exists(f) ? fmtf[f] : 2'b00;
    pr = (f >= 3 && acc.exists(f - 3)) ? acc[f - 3] : '0;
    left = b < 32;
    w  = left ? pr[47:24] : pr[23:0];
    e_lr = (ef == 2'b11) ? !left : left;
    e_d = 1'b0;
    case (ef)
      2'b00: if (s >= 16) e_d = w[39 - s];
      2'b01: if (s >= 8) e_d = w[31 - s];
      2'b10: if (s < 24) e_d = w[23 - s];
      default: if (s >= 1 && s <= 24) e_d = w[24 - s];
    endcase
    e_d = e_d & pr[49];
    chk("R2 bit clock", bck, (t % DIV) >= DIV / 2);
    chk("R3 frame clock polarity", lrck, e_lr);
    case (ef)
      2'b00: chk("R7/R8/R1 data 16-bit right-justified", sdata, e_d);
      2'b01: chk("R6/R8/R1 data 24-bit right-justified", sdata, e_d);
      2'b10: chk("R4/R8/R1 data left-justified", sdata, e_d);
      default: chk("R5/R8/R1 data I2S", sdata, e_d);
    endcase
    chk("R9 block frame", bframe, pr[49] & pr[48]);
  end

  initial begin
    #(CLK_PER * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    fmtf[0] = 2'b00;
    repeat (5) @(negedge clk);
    // R11 reset state
    chk("R11 reset data", sdata, 1'b0);
    chk("R11 reset block frame", bframe, 1'b0);
    chk("R11 reset frame clock", lrck, 1'b1);
    rst = 1'b0;
    for (int fi = 0; fi < NFR + 4; fi++) begin
      for (int c = 0; c < FR; c++) begin
        vin = 1'b0;
        bin = 1'b0;
        if (fi < NFR) begin
          // R10: group changes mid-frame; frame 21 changes in the last clock
          if (fi % 7 == 0 && fi != 21 && fi != 0 && c == 100) fmt = 2'(fi / 7);
          if (fi == 20 && c == FR - 1) fmt = 2'b11;
          // R10: short glitch that must have no effect
          if (fi == 16 && c == 50) fmt = 2'b00;
          if (fi == 16 && c == 60) fmt = 2'b10;
          if (fi == 9) begin
            if (c == FR - 1) vin = 1'b1;   // R8 last-clock acceptance
          end else if (fi % 7 != 3) begin
            if (c == 37 + (fi * 13) % 150) vin = 1'b1;
            if (fi % 6 == 2 && c == 220) vin = 1'b1;  // R8 last pair wins
          end
          // R11: frames with fi%7==3 stay empty
          if (vin) begin
            lin = $urandom();
            rin = $urandom();
            if (fi == 4) begin lin = 24'h800000; rin = 24'h7FFFFF; end
            bin = (fi % 5 == 1);
          end
        end
        @(negedge clk);
      end
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule